// File: doc/BRIEF.md
# BCD Calendar Clock Register Set

This block keeps wall-clock time and calendar date as packed BCD fields: seconds, minutes, hours, day of week with a stored century flag, day of month, month and a two-digit year. A one-cycle pulse on `tick_1hz` advances the time by one second. Carries ripple through the calendar in the same cycle. Month lengths follow the calendar, and February gains a 29th day in leap years.

Software reaches the fields through a simple register port. A write updates one field only when the value is well-formed BCD and lies in that field's range; otherwise the field keeps its old value. Reads are combinational and return the current BCD values. Bit 7 of the seconds register is a run/halt control. While it is set, ticks are ignored, and counting resumes from the held value once it is cleared. The register port is a plain control interface with no valid/ready handshake: every write is accepted in its cycle and there is no back-pressure. The `YEAR_BASE` parameter gives the calendar year that a stored year of 00 stands for, for example 1900 or 1968. Leap years are computed from that base plus the stored year.

Top module: `bcd_rtc_regs`

Register map (`wr_addr`/`rd_addr`): 0 seconds, 1 minutes, 2 hours, 3 weekday/century, 4 date, 5 month, 6 year, 7 unused.

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday register 0x01 (weekday 1, century flag 0), date 0x01, month 0x01, year 0x00, with the halt bit clear.
- R2: A `tick_1hz` pulse with the halt bit clear and no write in the same cycle advances seconds by one in BCD (0x09 becomes 0x10), visible on the next cycle.
- R3: Seconds wrap 0x59→0x00 and carry into minutes. Minutes wrap 0x59→0x00 into hours. Hours wrap 0x23→0x00 into date and weekday. Month wraps 0x12→0x01 into year, and year wraps 0x99→0x00. All of these carries happen on one tick.
- R4: A day carry wraps the date to 0x01 and advances the month once the date has reached the month length: 31 days by default, 30 for months 04, 06, 09 and 11, and for month 02 either 29 when (YEAR_BASE + year) is divisible by 4 or 28 otherwise. A date written beyond the month's end also wraps at the next day carry.
- R5: The weekday (bits 2:0 of register 3) advances on each day carry and wraps from 7 to 1.
- R6: Bit 7 of every write to register 0 sets the halt bit, whether or not the seconds value is accepted. While the halt bit is set, ticks change no field. Register 0 reads return the halt bit in bit 7 and BCD seconds in bits 6:0.
- R7: A write keeps only the field bits (seconds and minutes 6:0, hours 5:0, date 5:0, month 4:0, year 7:0). It loads them only if both nibbles are at most 9 and the value lies in range: seconds and minutes 00–59, hours 00–23, date 01–31, month 01–12, year 00–99. Any other value leaves the field unchanged.
- R8: A write to register 3 always stores bit 6 as the century flag. It loads bits 2:0 as the weekday only if they are in 1–7. A read returns the century flag in bit 6, the weekday in bits 2:0, and zeros elsewhere.
- R9: A tick that coincides with a write is dropped: only the write takes effect in that cycle.
- R10: Address 7 reads 0x00 and writes to it change nothing. Bits outside a field read as 0 (minutes bit 7, hours bits 7:6, date bits 7:6, month bits 7:5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register index for reads |
| rd_data | output | 8 | Combinational read data |

## Verification
Directed cases set the clock just before the end of a year, the end of February in leap and non-leap years, and the end of 30-day months. These show whether each carry level and each month-length choice fires exactly once. Malformed writes (nibbles above 9, values just past a range, a zero month or weekday) tell the range check apart from simple masking. Writes that set the halt bit, and writes that arrive together with a tick, separate freezing from dropping. A seeded random mix of ticks and writes, both legal and arbitrary, is then compared register by register against a calendar model in the bench. This exposes any wrong interaction between carries, halting and field loads.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int NUM_CNT  = 6;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;

  localparam logic [7:0] CNT_MIN [NUM_CNT] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};

  typedef enum logic [2:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HOUR = 3'd2,
    RA_WDAY = 3'd3,
    RA_DATE = 3'd4,
    RA_MON  = 3'd5,
    RA_YEAR = 3'd6,
    RA_NONE = 3'd7
  } rtc_addr_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_in_range(input logic [7:0] v, input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter #(
  parameter logic [7:0] MIN_BCD = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] max_bcd,
  output logic [7:0] q,
  output logic       at_max
);
  import bcd_rtc_pkg::*;

  assign at_max = (q >= max_bcd);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= MIN_BCD;
    else if (ld)     q <= ld_val;
    else if (inc)    q <= at_max ? MIN_BCD : bcd_inc(q);
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && at_max && !ld |=> q == MIN_BCD); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !ld |=> $stable(q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !ld |=> q != $past(q)); // R2

endmodule

// File: rtl/bcd_month_len.sv
module bcd_month_len #(
  parameter int YEAR_BASE = 1900
) (
  input  logic [7:0] month_bcd,
  input  logic [7:0] year_bcd,
  output logic [7:0] days_bcd
);
  localparam logic [1:0] BASE_MOD4 = 2'(YEAR_BASE % 4);

  logic [6:0] year_bin;
  logic [1:0] cal_mod4;
  logic       leap;

  always_comb begin
    year_bin = 7'(year_bcd[7:4]) * 7'd10 + 7'(year_bcd[3:0]);
    cal_mod4 = year_bin[1:0] + BASE_MOD4;
    leap     = (cal_mod4 == 2'd0);
    case (month_bcd)
      8'h02:                      days_bcd = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: days_bcd = 8'h30;
      default:                    days_bcd = 8'h31;
    endcase
  end

endmodule

// File: rtl/bcd_field_writer.sv
module bcd_field_writer
  import bcd_rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [NUM_CNT-1:0] cnt_ld,
  output logic [7:0]         ld_val,
  output logic               wday_ld,
  output logic               halt_wr,
  output logic               cent_wr
);

  always_comb begin
    cnt_ld  = '0;
    ld_val  = '0;
    wday_ld = 1'b0;
    halt_wr = 1'b0;
    cent_wr = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        RA_SEC: begin
          halt_wr         = 1'b1;
          ld_val          = {1'b0, wr_data[6:0]};
          cnt_ld[IDX_SEC] = bcd_in_range(ld_val, 8'h00, 8'h59);
        end
        RA_MIN: begin
          ld_val          = {1'b0, wr_data[6:0]};
          cnt_ld[IDX_MIN] = bcd_in_range(ld_val, 8'h00, 8'h59);
        end
        RA_HOUR: begin
          ld_val           = {2'b00, wr_data[5:0]};
          cnt_ld[IDX_HOUR] = bcd_in_range(ld_val, 8'h00, 8'h23);
        end
        RA_WDAY: begin
          cent_wr = 1'b1;
          ld_val  = {5'd0, wr_data[2:0]};
          wday_ld = (wr_data[2:0] != 3'd0);
        end
        RA_DATE: begin
          ld_val           = {2'b00, wr_data[5:0]};
          cnt_ld[IDX_DATE] = bcd_in_range(ld_val, 8'h01, 8'h31);
        end
        RA_MON: begin
          ld_val          = {3'b000, wr_data[4:0]};
          cnt_ld[IDX_MON] = bcd_in_range(ld_val, 8'h01, 8'h12);
        end
        RA_YEAR: begin
          ld_val           = wr_data;
          cnt_ld[IDX_YEAR] = bcd_in_range(ld_val, 8'h00, 8'h99);
        end
        default: ;
      endcase
    end
  end

  AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_ld, wday_ld})); // R7
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (cnt_ld == '0) && !wday_ld && !halt_wr && !cent_wr); // R10

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import bcd_rtc_pkg::*;
#(
  parameter int YEAR_BASE = 1900
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);

  logic [7:0]         cnt_q   [NUM_CNT];
  logic [7:0]         cnt_max [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_at_max;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [NUM_CNT-1:0] cnt_ld;
  logic [7:0]         ld_val;
  logic [7:0]         days_bcd;
  logic               wday_ld, halt_wr, cent_wr;
  logic               halt_q, cent_q;
  logic [2:0]         wday_q;
  logic               day_carry;

  bcd_field_writer u_writer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_ld(cnt_ld), .ld_val(ld_val), .wday_ld(wday_ld),
    .halt_wr(halt_wr), .cent_wr(cent_wr)
  );

  bcd_month_len #(.YEAR_BASE(YEAR_BASE)) u_mlen (
    .month_bcd(cnt_q[IDX_MON]), .year_bcd(cnt_q[IDX_YEAR]), .days_bcd(days_bcd)
  );

  always_comb begin
    cnt_max[IDX_SEC]  = 8'h59;
    cnt_max[IDX_MIN]  = 8'h59;
    cnt_max[IDX_HOUR] = 8'h23;
    cnt_max[IDX_DATE] = days_bcd;
    cnt_max[IDX_MON]  = 8'h12;
    cnt_max[IDX_YEAR] = 8'h99;
  end

  // carry chain: any write in the cycle drops the tick
  always_comb begin
    cnt_inc[0] = tick_1hz && !halt_q && !wr_en;
    for (int i = 1; i < NUM_CNT; i++) cnt_inc[i] = cnt_inc[i-1] && cnt_at_max[i-1];
  end
  assign day_carry = cnt_inc[IDX_DATE];

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    bcd_wrap_counter #(.MIN_BCD(CNT_MIN[gi])) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[gi]), .ld(cnt_ld[gi]), .ld_val(ld_val),
      .max_bcd(cnt_max[gi]), .q(cnt_q[gi]), .at_max(cnt_at_max[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      cent_q <= 1'b0;
      wday_q <= 3'd1;
    end else begin
      if (halt_wr) halt_q <= wr_data[7];
      if (cent_wr) cent_q <= wr_data[6];
      if (wday_ld)        wday_q <= ld_val[2:0];
      else if (day_carry) wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
    end
  end

  always_comb begin
    case (rd_addr)
      RA_SEC:  rd_data = {halt_q, cnt_q[IDX_SEC][6:0]};
      RA_MIN:  rd_data = {1'b0, cnt_q[IDX_MIN][6:0]};
      RA_HOUR: rd_data = {2'b00, cnt_q[IDX_HOUR][5:0]};
      RA_WDAY: rd_data = {1'b0, cent_q, 3'b000, wday_q};
      RA_DATE: rd_data = {2'b00, cnt_q[IDX_DATE][5:0]};
      RA_MON:  rd_data = {3'b000, cnt_q[IDX_MON][4:0]};
      RA_YEAR: rd_data = cnt_q[IDX_YEAR];
      default: rd_data = 8'h00;
    endcase
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q && !wr_en |=> $stable(cnt_q[IDX_SEC]) && $stable(wday_q)); // R6
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wday_q != 3'd0); // R5
  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry && !wday_ld && wday_q == 3'd7 |=> wday_q == 3'd1); // R5
  AST_TICK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tick_1hz && wr_addr != RA_SEC |=> $stable(cnt_q[IDX_SEC])); // R9
  AST_MON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == RA_MON && wr_data[4:0] == 5'h13 |=> $stable(cnt_q[IDX_MON])); // R7
  AST_DATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry && !cnt_ld[IDX_DATE] && cnt_q[IDX_DATE] >= days_bcd |=> cnt_q[IDX_DATE] == 8'h01); // R4

endmodule

// File: tb/bcd_rtc_regs_tb_top.sv
module bcd_rtc_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_sec, m_min, m_hr, m_wday, m_date, m_mon, m_yr;
  bit m_halt, m_cent;

  always #5 clk = ~clk;

  bcd_rtc_regs #(.YEAR_BASE(1900)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] v);
    if (v[3:0] > 4'd9 || v[7:4] > 4'd9) return -1;
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int month_days(input int mon, input int yr);
    if (mon == 2) return ((1900 + yr) % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic void model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_wday = 1; m_date = 1; m_mon = 1; m_yr = 0;
    m_halt = 0; m_cent = 0;
  endfunction

  function automatic void model_tick();
    if (m_halt) return;
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_hr < 23) begin m_hr++; return; end
    m_hr = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    if (m_date < month_days(m_mon, m_yr)) begin m_date++; return; end
    m_date = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    m_yr = (m_yr == 99) ? 0 : m_yr + 1;
  endfunction

  function automatic void model_write(input int a, input logic [7:0] d);
    int v;
    case (a)
      0: begin m_halt = d[7]; v = from_bcd(d & 8'h7F); if (v >= 0 && v <= 59) m_sec = v; end
      1: begin v = from_bcd(d & 8'h7F); if (v >= 0 && v <= 59) m_min = v; end
      2: begin v = from_bcd(d & 8'h3F); if (v >= 0 && v <= 23) m_hr = v; end
      3: begin m_cent = d[6]; if (d[2:0] != 3'd0) m_wday = int'(d[2:0]); end
      4: begin v = from_bcd(d & 8'h3F); if (v >= 1 && v <= 31) m_date = v; end
      5: begin v = from_bcd(d & 8'h1F); if (v >= 1 && v <= 12) m_mon = v; end
      6: begin v = from_bcd(d); if (v >= 0 && v <= 99) m_yr = v; end
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    case (a)
      0: return {m_halt, to_bcd(m_sec)[6:0]};
      1: return to_bcd(m_min);
      2: return to_bcd(m_hr);
      3: return {1'b0, m_cent, 3'b000, 3'(m_wday)};
      4: return to_bcd(m_date);
      5: return to_bcd(m_mon);
      6: return to_bcd(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.5;
      checks++;
      if (rd_data !== exp_read(a)) begin
        fails++;
        $display("FAIL %s reg%0d actual=%02h expected=%02h", tag, a, rd_data, exp_read(a));
      end
    end
  endtask

  // one cycle of stimulus, then compare every register
  task automatic do_op(input bit w, input int a, input logic [7:0] d, input bit t, input string tag);
    @(negedge clk);
    wr_en = w; wr_addr = 3'(a); wr_data = d; tick_1hz = t;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    if (w) model_write(a, d);
    else if (t) model_tick();
    check_all(tag);
  endtask

  task automatic set_clock(input int yr, input int mon, input int dt, input int wd,
                           input int hr, input int mi, input int sc);
    do_op(1, 6, to_bcd(yr), 0, "R7 load year");
    do_op(1, 5, to_bcd(mon), 0, "R7 load month");
    do_op(1, 4, to_bcd(dt), 0, "R7 load date");
    do_op(1, 3, 8'(wd), 0, "R8 load weekday");
    do_op(1, 2, to_bcd(hr), 0, "R7 load hours");
    do_op(1, 1, to_bcd(mi), 0, "R7 load minutes");
    do_op(1, 0, to_bcd(sc), 0, "R7 load seconds");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset values");

    do_op(1, 0, 8'h09, 0, "R7 seconds load");
    do_op(0, 0, 8'h00, 1, "R2 tick BCD step");
    do_op(0, 0, 8'h00, 1, "R2 tick again");

    set_clock(99, 12, 31, 7, 23, 59, 59);
    do_op(0, 0, 8'h00, 1, "R3 R5 full rollover");

    set_clock(4, 2, 28, 3, 23, 59, 59);
    do_op(0, 0, 8'h00, 1, "R4 leap Feb 29");
    set_clock(4, 2, 29, 3, 23, 59, 59);
    do_op(0, 0, 8'h00, 1, "R4 leap end of Feb");
    set_clock(1, 2, 28, 3, 23, 59, 59);
    do_op(0, 0, 8'h00, 1, "R4 non-leap end of Feb");
    set_clock(1, 4, 30, 6, 23, 59, 59);
    do_op(0, 0, 8'h00, 1, "R4 30-day month");
    set_clock(1, 2, 31, 2, 23, 59, 59);
    do_op(0, 0, 8'h00, 1, "R4 date past month end");

    do_op(1, 0, 8'hB0, 0, "R6 halt set with load");
    do_op(0, 0, 8'h00, 1, "R6 tick while halted");
    do_op(1, 0, 8'hFA, 0, "R6 halt bit kept on rejected value");
    do_op(1, 0, 8'h30, 0, "R6 release halt");
    do_op(0, 0, 8'h00, 1, "R6 counting resumes");

    do_op(1, 0, 8'h5A, 0, "R7 seconds bad nibble");
    do_op(1, 0, 8'h60, 0, "R7 seconds over range");
    do_op(1, 1, 8'h60, 0, "R7 minutes over range");
    do_op(1, 2, 8'h24, 0, "R7 hours over range");
    do_op(1, 2, 8'hE3, 0, "R7 hours masked bits");
    do_op(1, 4, 8'h32, 0, "R7 date over range");
    do_op(1, 4, 8'h00, 0, "R7 date zero");
    do_op(1, 5, 8'h13, 0, "R7 month over range");
    do_op(1, 5, 8'h00, 0, "R7 month zero");
    do_op(1, 6, 8'hA5, 0, "R7 year bad nibble");
    do_op(1, 3, 8'h47, 0, "R8 century and weekday");
    do_op(1, 3, 8'h00, 0, "R8 weekday zero rejected");
    do_op(1, 6, 8'h42, 1, "R9 tick dropped by write");
    do_op(1, 5, 8'h13, 1, "R9 tick dropped by rejected write");
    do_op(1, 7, 8'hFF, 0, "R10 unused address");
    do_op(1, 1, 8'hD9, 0, "R10 masked minutes bit 7");

    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 99);
      int a = $urandom_range(0, 7);
      logic [7:0] d = 8'($urandom);
      if (r < 50) do_op(0, 0, 8'h00, 1, "R2 R3 random tick");
      else if (r < 90) begin
        if ($urandom_range(0, 2) != 0) begin
          case (a)
            0: d = to_bcd($urandom_range(50, 59)) | (($urandom_range(0, 3) == 0) ? 8'h80 : 8'h00);
            1: d = to_bcd($urandom_range(55, 59));
            2: d = to_bcd($urandom_range(20, 23));
            3: d = 8'($urandom_range(0, 7)) | 8'($urandom_range(0, 1) << 6);
            4: d = to_bcd($urandom_range(26, 31));
            5: d = to_bcd($urandom_range(1, 12));
            6: d = to_bcd($urandom_range(0, 99));
            default: ;
          endcase
        end
        do_op(1, a, d, 0, "R7 R8 random write");
      end else do_op(1, a, d, 1, "R9 random write with tick");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule